// File: doc/BRIEF.md
# Infix-to-Postfix Expression Reorderer

This block takes an arithmetic expression as a stream of bytes in infix order and sends it out again in postfix order. A postfix evaluator placed after it can then compute the result with a plain value stack. Operand bytes pass through unchanged. Operator and parenthesis bytes are held on an internal operator stack and are released according to precedence, associativity and bracket nesting. Both stream ports use a valid/ready handshake.

Each expression ends with the byte 0xFF. When the block sees that byte, it releases every operator it still holds and then forwards 0xFF. A malformed expression raises an error flag, and the block drops the rest of that expression. The malformed cases are a close bracket with no open bracket, an open bracket that is never closed, stack overflow and an unknown code. The block resumes normal work at the next expression.

Top module: `infix_postfix_conv`

## Requirements
- R1: An operand byte (bit 7 clear) is forwarded unchanged, and operands leave in the order they arrived.
- R2: Operator codes are 0x80 add, 0x81 subtract, 0x82 multiply and 0x83 power. Power binds tighter than multiply, and multiply binds tighter than add and subtract, which share one level.
- R3: Add and subtract group left to right (a-b-c gives a b - c -). Power groups right to left (a^b^c gives a b c ^ ^).
- R4: The open bracket 0x85 and the close bracket 0x86 may appear anywhere. A close bracket releases the stacked operators down to its matching open bracket, and neither bracket byte is ever output.
- R5: On the end marker 0xFF, all operators still stacked are output from the top of the stack down, and then 0xFF is output.
- R6: A close bracket with no open bracket, or an open bracket still stacked when 0xFF arrives, sets err_o. Nothing more from that expression is output, including its 0xFF.
- R7: Pushing an operator or open bracket while STACK_DEPTH entries are already held sets err_o. The block then discards input bytes up to and including 0xFF. Exactly STACK_DEPTH nested brackets are accepted without error.
- R8: A byte with bit 7 set that is not 0x80–0x83, 0x85, 0x86 or 0xFF sets err_o, with the same dropping as in R7.
- R9: err_o stays high from the cycle after the fault until the first byte of the next expression is accepted. If that byte is not itself faulty, err_o then clears.
- R10: While out_valid_o is high and out_ready_i is low, out_data_o holds its value and no input byte is accepted.
- R11: After reset, out_valid_o and err_o are low, the stack is empty, and an operand is accepted at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte present |
| in_data_i | input | 8 | Input byte, infix order |
| in_ready_o | output | 1 | Input byte accepted this cycle when valid |
| out_valid_o | output | 1 | Output byte present |
| out_data_o | output | 8 | Output byte, postfix order |
| out_ready_i | input | 1 | Downstream takes the output byte |
| err_o | output | 1 | Malformed expression detected |

## Verification
A wrong stack pointer or a corrupted stack entry shows up at out_data_o as a misplaced or wrong operator code. It appears at the latest when the next close bracket or end marker forces the stack to drain, which for these vectors is within a few bytes. A fault in the drop mode shows one cycle after the offending byte: either the output keeps flowing after err_o rises, or err_o stays high into the following expression. The vectors apply output backpressure every third cycle, so a handshake error reorders or repeats bytes in the captured stream.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_ADD = 8'h80;
    localparam logic [BYTE_W-1:0] CODE_SUB = 8'h81;
    localparam logic [BYTE_W-1:0] CODE_MUL = 8'h82;
    localparam logic [BYTE_W-1:0] CODE_POW = 8'h83;
    localparam logic [BYTE_W-1:0] CODE_LPAR = 8'h85;
    localparam logic [BYTE_W-1:0] CODE_RPAR = 8'h86;
    localparam logic [BYTE_W-1:0] CODE_END = 8'hFF;

    typedef enum logic [3:0] {
        TK_OPND, TK_ADD, TK_SUB, TK_MUL, TK_POW,
        TK_LPAR, TK_RPAR, TK_END, TK_BAD
    } tok_e;

    typedef enum logic {ST_TAKE, ST_SKIP} mode_e;

    // binding strength; 0 means "not an arithmetic operator"
    function automatic logic [1:0] tok_rank(tok_e t);
        case (t)
            TK_POW:          return 2'd3;
            TK_MUL:          return 2'd2;
            TK_ADD, TK_SUB:  return 2'd1;
            default:         return 2'd0;
        endcase
    endfunction

    // true when the stacked operator must leave before the incoming one is pushed
    function automatic logic yields_to(tok_e top, tok_e inc);
        logic [1:0] rt;
        logic [1:0] ri;
        rt = tok_rank(top);
        ri = tok_rank(inc);
        return (rt != 2'd0) && ((rt > ri) || ((rt == ri) && (inc != TK_POW)));
    endfunction

    function automatic logic [BYTE_W-1:0] tok_code(tok_e t);
        case (t)
            TK_ADD:  return CODE_ADD;
            TK_SUB:  return CODE_SUB;
            TK_MUL:  return CODE_MUL;
            TK_POW:  return CODE_POW;
            default: return CODE_END;
        endcase
    endfunction

endpackage

// File: rtl/ipc_classify.sv
module ipc_classify
    import ipc_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output tok_e              tok_o
);

    always_comb begin
        if (!byte_i[BYTE_W-1]) begin
            tok_o = TK_OPND;
        end else begin
            case (byte_i)
                CODE_ADD:  tok_o = TK_ADD;
                CODE_SUB:  tok_o = TK_SUB;
                CODE_MUL:  tok_o = TK_MUL;
                CODE_POW:  tok_o = TK_POW;
                CODE_LPAR: tok_o = TK_LPAR;
                CODE_RPAR: tok_o = TK_RPAR;
                CODE_END:  tok_o = TK_END;
                default:   tok_o = TK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/ipc_op_stack.sv
module ipc_op_stack
    import ipc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic push_i,
    input  logic pop_i,
    input  logic clear_i,
    input  tok_e push_tok_i,
    output tok_e top_o,
    output logic empty_o,
    output logic full_o
);

    localparam int PTR_W = $clog2(DEPTH + 1);

    typedef struct packed {
        tok_e [DEPTH-1:0]  slot;
        logic [PTR_W-1:0]  cnt;
    } stk_t;

    stk_t stk_q, stk_d;

    always_comb begin
        stk_d = stk_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (push_i && (stk_q.cnt == PTR_W'(i))) begin
                stk_d.slot[i] = push_tok_i;
            end
        end
        if (clear_i) begin
            stk_d.cnt = '0;
        end else if (push_i) begin
            stk_d.cnt = stk_q.cnt + 1'b1;
        end else if (pop_i) begin
            stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_comb begin
        top_o = TK_BAD;
        for (int i = 0; i < DEPTH; i++) begin
            if (stk_q.cnt == PTR_W'(i + 1)) begin
                top_o = stk_q.slot[i];
            end
        end
    end

    assign empty_o = (stk_q.cnt == '0);
    assign full_o  = (stk_q.cnt == PTR_W'(DEPTH));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    // the controller must never push onto a full stack (R7)
    p_push_room_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> !full_o);

    // releases only happen while something is held (R4)
    p_pop_nonempty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o);

endmodule

// File: rtl/infix_postfix_conv.sv
module infix_postfix_conv
    import ipc_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              err_o
);

    typedef struct packed {
        mode_e             mode;
        logic              err;
        logic              ov;
        logic [BYTE_W-1:0] od;
    } core_t;

    core_t cur_q, nxt_d;

    tok_e tok;
    tok_e st_top;
    logic st_empty, st_full;
    logic st_push, st_pop, st_clear;

    logic              take;
    logic              emit;
    logic              fault;
    logic              slot_free;
    logic [BYTE_W-1:0] emit_byte;

    ipc_classify u_cls (
        .byte_i (in_data_i),
        .tok_o  (tok)
    );

    ipc_op_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (st_push),
        .pop_i      (st_pop),
        .clear_i    (st_clear),
        .push_tok_i (tok),
        .top_o      (st_top),
        .empty_o    (st_empty),
        .full_o     (st_full)
    );

    always_comb begin
        nxt_d     = cur_q;
        take      = 1'b0;
        emit      = 1'b0;
        fault     = 1'b0;
        st_push   = 1'b0;
        st_pop    = 1'b0;
        st_clear  = 1'b0;
        emit_byte = in_data_i;
        slot_free = !cur_q.ov || out_ready_i;

        if (cur_q.ov && out_ready_i) begin
            nxt_d.ov = 1'b0;
        end

        if (cur_q.mode == ST_SKIP) begin
            take = 1'b1;
        end else if (slot_free) begin
            case (tok)
                TK_OPND: begin
                    take = 1'b1;
                    emit = 1'b1;
                end
                TK_ADD, TK_SUB, TK_MUL, TK_POW: begin
                    if (!st_empty && yields_to(st_top, tok)) begin
                        st_pop    = 1'b1;
                        emit      = 1'b1;
                        emit_byte = tok_code(st_top);
                    end else if (st_full) begin
                        take  = 1'b1;
                        fault = 1'b1;
                    end else begin
                        take    = 1'b1;
                        st_push = 1'b1;
                    end
                end
                TK_LPAR: begin
                    take = 1'b1;
                    if (st_full) begin
                        fault = 1'b1;
                    end else begin
                        st_push = 1'b1;
                    end
                end
                TK_RPAR: begin
                    if (st_empty) begin
                        take  = 1'b1;
                        fault = 1'b1;
                    end else if (st_top == TK_LPAR) begin
                        take   = 1'b1;
                        st_pop = 1'b1;
                    end else begin
                        st_pop    = 1'b1;
                        emit      = 1'b1;
                        emit_byte = tok_code(st_top);
                    end
                end
                TK_END: begin
                    if (st_empty) begin
                        take = 1'b1;
                        emit = 1'b1;
                    end else if (st_top == TK_LPAR) begin
                        take  = 1'b1;
                        fault = 1'b1;
                    end else begin
                        st_pop    = 1'b1;
                        emit      = 1'b1;
                        emit_byte = tok_code(st_top);
                    end
                end
                default: begin
                    take  = 1'b1;
                    fault = 1'b1;
                end
            endcase
        end

        // nothing happens without a presented byte
        st_push = st_push && in_valid_i;
        st_pop  = st_pop && in_valid_i;
        emit    = emit && in_valid_i;

        if (in_valid_i && take) begin
            if (cur_q.mode == ST_SKIP) begin
                if (tok == TK_END) begin
                    nxt_d.mode = ST_TAKE;
                end
            end else if (fault) begin
                nxt_d.err  = 1'b1;
                st_clear   = 1'b1;
                nxt_d.mode = (tok == TK_END) ? ST_TAKE : ST_SKIP;
            end else begin
                nxt_d.err = 1'b0;
            end
        end

        if (emit) begin
            nxt_d.ov = 1'b1;
            nxt_d.od = emit_byte;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{mode: ST_TAKE, err: 1'b0, ov: 1'b0, od: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign in_ready_o  = take;
    assign out_valid_o = cur_q.ov;
    assign out_data_o  = cur_q.od;
    assign err_o       = cur_q.err;

    // a stalled output byte stays put (R10)
    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // no intake while the output register is blocked in normal mode (R10)
    p_stall_intake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i && cur_q.mode == ST_TAKE) |-> !in_ready_o);

    // dropping mode never starts a new output byte (R6)
    p_skip_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.mode == ST_SKIP) |=> !$rose(out_valid_o));

    // the error flag only rises on an accepted byte (R9)
    p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> $past(in_valid_i && in_ready_o));

endmodule

// File: tb/infix_postfix_conv_tb.sv
`timescale 1ns/1ps
module infix_postfix_conv_tb;

    typedef struct packed {
        logic [191:0] stim;   // byte j at [8j +: 8]
        logic [191:0] want;
        logic [7:0]   want_len;
        logic         err;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{192'hFF_04_80_03, 192'hFF_80_04_03, 8'd4, 1'b0},
        '{192'hFF_04_80_03_82_02, 192'hFF_80_04_82_03_02, 8'd6, 1'b0},
        '{192'hFF_04_82_03_80_02, 192'hFF_80_82_04_03_02, 8'd6, 1'b0},
        '{192'hFF_01_81_02_81_09, 192'hFF_81_01_81_02_09, 8'd6, 1'b0},
        '{192'hFF_02_83_03_83_02, 192'hFF_83_83_02_03_02, 8'd6, 1'b0},
        '{192'hFF_04_82_86_03_80_02_85, 192'hFF_82_04_80_03_02, 8'd6, 1'b0},
        '{192'hFF_02_83_86_04_80_03_85_82_02, 192'hFF_82_83_02_80_04_03_02, 8'd8, 1'b0},
        '{192'hFF_04_82_03_83_02, 192'hFF_82_04_83_03_02, 8'd6, 1'b0},
        '{192'hFF_01_81_03_80_05, 192'hFF_81_01_80_03_05, 8'd6, 1'b0},
        '{192'hFF_86_86_01_85_85, 192'hFF_01, 8'd2, 1'b0},
        '{192'hFF_80_03_86_02, 192'h02, 8'd1, 1'b1},
        '{192'hFF_05, 192'hFF_05, 8'd2, 1'b0},
        '{192'hFF_03_80_02_85, 192'h80_03_02, 8'd3, 1'b1},
        '{192'hFF_03_84_02, 192'h02, 8'd1, 1'b1},
        '{192'hFF_01_85_85_85_85_85_85_85_85_85, 192'h0, 8'd0, 1'b1},
        '{192'hFF_86_86_86_86_86_86_86_86_01_85_85_85_85_85_85_85_85, 192'hFF_01, 8'd2, 1'b0}
    };

    function automatic string vec_req(int i);
        case (i)
            0:       return "R1/R5";
            1, 2, 7: return "R2";
            3, 4, 8: return "R3";
            5, 9:    return "R4";
            6:       return "R4/R5";
            10, 12:  return "R6";
            11:      return "R9";
            13:      return "R8";
            default: return "R7";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] got [32];
    int got_n = 0;

    always #4 clk = ~clk;

    infix_postfix_conv u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .in_ready_o  (in_ready),
        .out_valid_o (out_valid),
        .out_data_o  (out_data),
        .out_ready_i (out_ready),
        .err_o       (err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic grab();
        if (out_valid && out_ready && got_n < 32) begin
            got[got_n] = out_data;
            got_n++;
        end
    endtask

    task automatic run_vec(input vec_t tv, input string tag);
        int si;
        int guard;
        bit sent_end;
        si = 0;
        guard = 0;
        sent_end = 1'b0;
        got_n = 0;
        while (!sent_end && guard < 300) begin
            @(negedge clk);
            guard++;
            cyc++;
            out_ready = (cyc % 3) != 2;
            in_valid = 1'b1;
            in_data = tv.stim[si*8 +: 8];
            #1;
            grab();
            if (in_ready) begin
                if (in_data == 8'hFF) sent_end = 1'b1;
                si++;
            end
        end
        chk(sent_end, tag, "input stream completes", int'(sent_end), 1);
        repeat (10) begin
            @(negedge clk);
            in_valid = 1'b0;
            out_ready = 1'b1;
            #1;
            grab();
        end
        chk(got_n == int'(tv.want_len), tag, "output byte count", got_n, int'(tv.want_len));
        for (int j = 0; j < int'(tv.want_len); j++) begin
            chk(got[j] == tv.want[j*8 +: 8], tag, $sformatf("output byte %0d", j),
                int'(got[j]), int'(tv.want[j*8 +: 8]));
        end
        chk(err == tv.err, tag, "error flag", int'(err), int'(tv.err));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (R1..R11 run) actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // reset state (R11)
        chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        chk(err == 1'b0, "R11", "err after reset", int'(err), 0);
        chk(in_ready == 1'b1, "R11", "operand accepted after reset", int'(in_ready), 1);

        for (int v = 0; v < NVEC; v++) begin
            run_vec(VECS[v], vec_req(v));
        end

        // backpressure (R10)
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1;
        in_data = 8'h07;
        #1;
        chk(in_ready == 1'b1, "R10", "empty output takes byte", int'(in_ready), 1);
        @(negedge clk);
        in_data = 8'h08;
        #1;
        chk(out_valid == 1'b1, "R10", "first byte presented", int'(out_valid), 1);
        chk(in_ready == 1'b0, "R10", "intake blocked by stall", int'(in_ready), 0);
        repeat (3) begin
            @(negedge clk);
            #1;
            chk(out_data == 8'h07, "R10", "held byte", int'(out_data), 8'h07);
            chk(in_ready == 1'b0, "R10", "still blocked", int'(in_ready), 0);
        end
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R10", "intake resumes", int'(in_ready), 1);
        @(negedge clk);
        in_data = 8'hFF;
        #1;
        chk(out_data == 8'h08 && out_valid, "R10", "next byte follows", int'(out_data), 8'h08);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_data == 8'hFF && out_valid, "R5", "end marker after stall", int'(out_data), 8'hFF);
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule